// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block holds audio sample words for one transfer direction between a processor register bus and a serial audio port. In the playback build, the processor writes words into a data register and the serial side takes them out. In the capture build, the serial side puts words in and the processor reads them out through the same data register. Words are 24 bits wide. A 16-bit sample travels in data bits 23:8.

Storage is `256 << SIZE_CODE` words. The number of usable frames is that word count halved once for every doubling needed to reach the channel count. For example, with 256 words and 3 channels there are 64 frames, which is 192 words. The processor reads the fill level in whole frames. It also sees sticky overrun and underrun flags. A level interrupt request follows the half-capacity point. A clear command empties the store in one cycle.

Register map on the 2-bit address: 0 is the data register, 1 is the control register and 2 is the status register. Address 3 reads as zero. The write bus carries the 24 bits that a register keeps.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty, the status register reads 0, the control register reads 0 and `irq_half` is low.
- R2: Frame capacity is `(256 << SIZE_CODE) >> clog2(CHANNELS)`. The FIFO accepts exactly frame capacity times CHANNELS words before it is full.
- R3: Status bits 16:8 give the number of whole frames stored (stored words divided by CHANNELS, rounded down, saturating at 511). Every other bit except 4 and 0 reads zero.
- R4: Words leave the FIFO in the order they entered, with all 24 written bits intact.
- R5: A push into a full FIFO drops the word and sets status bit 4, which then stays set.
- R6: A pop from an empty FIFO returns zero data, leaves the fill unchanged and sets status bit 0, which then stays set.
- R7: A write to the status register clears each flag whose bit (4 or 0) is written as 0. Writing 0 clears both flags. A flag set in the same cycle takes priority over the clear.
- R8: Writing control bit 0 as 1 empties the FIFO by the next cycle. The error flags are kept, any push or pop in that cycle is discarded, and bit 0 reads back as 0.
- R9: Control bit 20 enables `irq_half` and reads back. When enabled, `irq_half` is high while frames are at most half of frame capacity (playback) or at least half of frame capacity (capture).
- R10: Playback pushes on data-register writes and pops on `ser_pop`. Capture pushes on `ser_push` and pops on data-register reads. The other direction's strobes have no effect, and a data-register read in playback returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops in capture on the data address) |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| ser_push | input | 1 | Serial-side push (capture) |
| ser_pdata | input | 24 | Serial-side push word |
| ser_pop | input | 1 | Serial-side pop (playback) |
| ser_rdata | output | 24 | Word presented during a serial pop, zero otherwise |
| irq_half | output | 1 | Half-level interrupt request, level |

## Verification
Read data on `reg_rdata` and `ser_rdata` appears combinationally in the same cycle as the strobe. Fill level, flags, clear and `irq_half` change at the clock edge that takes the strobe, so they are visible one edge later. The bench drives each strobe at a falling edge and samples read data 1 ns later, before the rising edge. It removes the strobe at the next falling edge and checks status and `irq_half` there, after exactly one rising edge. Playback with two channels and capture with three channels are swept word by word across the whole depth. At every fill level the frame count and interrupt level are compared with values the bench computes arithmetically.

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int SIZE_CODE = 0,
  parameter int CHANNELS  = 2,
  parameter bit CAPTURE   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [23:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ser_push,
  input  logic [23:0] ser_pdata,
  input  logic        ser_pop,
  output logic [23:0] ser_rdata,
  output logic        irq_half
);

  localparam int WORD_CAP  = 256 << SIZE_CODE;
  localparam int FRAME_CAP = WORD_CAP >> $clog2(CHANNELS);
  localparam int USED      = FRAME_CAP * CHANNELS;
  localparam int HALF      = FRAME_CAP / 2;
  localparam int AW        = $clog2(WORD_CAP);
  localparam int FW        = AW + 1;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [23:0]   mem [WORD_CAP];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] count, frames;
  logic [8:0]    frames_fld;
  logic          ovr, udr, irq_en;

  wire data_wr = reg_wr && reg_addr == A_DATA;
  wire data_rd = reg_rd && reg_addr == A_DATA;
  wire ctrl_wr = reg_wr && reg_addr == A_CTRL;
  wire stat_wr = reg_wr && reg_addr == A_STAT;
  wire clr     = ctrl_wr && reg_wdata[0];

  wire        push_req  = CAPTURE ? ser_push  : data_wr;
  wire [23:0] push_word = CAPTURE ? ser_pdata : reg_wdata;
  wire        pop_req   = CAPTURE ? data_rd   : ser_pop;

  wire full    = count == FW'(USED);
  wire empty   = count == '0;
  wire do_push = push_req && !full && !clr;
  wire do_pop  = pop_req && !empty && !clr;
  wire set_ovr = push_req && full && !clr;
  wire set_udr = pop_req && empty && !clr;

  wire [23:0] head = empty ? 24'd0 : mem[rd_ptr];

  assign frames     = count / FW'(CHANNELS);
  assign frames_fld = (frames > FW'(511)) ? 9'd511 : frames[8:0];

  assign irq_half = irq_en && (CAPTURE ? (frames >= FW'(HALF)) : (frames <= FW'(HALF)));
  assign ser_rdata = (!CAPTURE && ser_pop) ? head : 24'd0;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = CAPTURE ? {8'd0, head} : 32'd0;
      A_CTRL:  reg_rdata = {11'd0, irq_en, 20'd0};
      A_STAT:  reg_rdata = {15'd0, frames_fld, 3'd0, ovr, 3'd0, udr};
      default: reg_rdata = 32'd0;
    endcase
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(USED - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr    <= 1'b0;
      udr    <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (ctrl_wr) irq_en <= reg_wdata[20];
      if (set_ovr)     ovr <= 1'b1;
      else if (stat_wr) ovr <= ovr & reg_wdata[4];
      if (set_udr)     udr <= 1'b1;
      else if (stat_wr) udr <= udr & reg_wdata[0];
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FW'(USED));

  assert_overrun_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !clr) |=> (reg_rdata[4] || reg_addr != A_STAT) && ovr);

  assert_overrun_keeps_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !clr && !pop_req) |=> $stable(count));

  assert_underrun_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !clr) |=> udr && $stable(count));

  assert_underrun_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!CAPTURE && ser_pop && empty) |-> ser_rdata == 24'd0);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0 && frames_fld == 9'd0);

  assert_clear_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ovr) |=> ovr);

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (count == $past(count) || count == $past(count) + 1'b1 ||
                     count == $past(count) - 1'b1));

endmodule

// File: tb/audio_sample_fifo_tb.sv
`timescale 1ns/1ps
module audio_sample_fifo_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic        p_wr = 0, p_rd = 0, p_spush = 0, p_spop = 0;
  logic [1:0]  p_addr = 0;
  logic [23:0] p_wdata = 0, p_sdata = 0;
  logic [31:0] p_rdata;
  logic [23:0] p_srdata;
  logic        p_irq;

  logic        c_wr = 0, c_rd = 0, c_spush = 0, c_spop = 0;
  logic [1:0]  c_addr = 0;
  logic [23:0] c_wdata = 0, c_sdata = 0;
  logic [31:0] c_rdata;
  logic [23:0] c_srdata;
  logic        c_irq;

  audio_sample_fifo #(.SIZE_CODE(0), .CHANNELS(2), .CAPTURE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(p_wr), .reg_rd(p_rd), .reg_addr(p_addr),
    .reg_wdata(p_wdata), .reg_rdata(p_rdata), .ser_push(p_spush), .ser_pdata(p_sdata),
    .ser_pop(p_spop), .ser_rdata(p_srdata), .irq_half(p_irq));

  audio_sample_fifo #(.SIZE_CODE(0), .CHANNELS(3), .CAPTURE(1'b1)) u_dut_cap (
    .clk(clk), .rst_n(rst_n), .reg_wr(c_wr), .reg_rd(c_rd), .reg_addr(c_addr),
    .reg_wdata(c_wdata), .reg_rdata(c_rdata), .ser_push(c_spush), .ser_pdata(c_sdata),
    .ser_pop(c_spop), .ser_rdata(c_srdata), .irq_half(c_irq));

  function automatic logic [23:0] pat(int n);
    return 24'(n * 40503 + 17);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic p_write(logic [1:0] a, logic [23:0] d);
    @(negedge clk); p_wr = 1; p_addr = a; p_wdata = d;
    @(negedge clk); p_wr = 0; p_addr = 0;
  endtask

  task automatic c_write(logic [1:0] a, logic [23:0] d);
    @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0; c_addr = 0;
  endtask

  task automatic p_peek(logic [1:0] a, output logic [31:0] v);
    p_addr = a; #1 v = p_rdata; p_addr = 0;
  endtask

  task automatic c_peek(logic [1:0] a, output logic [31:0] v);
    c_addr = a; #1 v = c_rdata; c_addr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    p_peek(2'd2, v); check("R1 play status", v, 0);
    p_peek(2'd1, v); check("R1 play ctrl", v, 0);
    check("R1 play irq", {31'd0, p_irq}, 0);
    c_peek(2'd2, v); check("R1 cap status", v, 0);
    check("R1 cap irq", {31'd0, c_irq}, 0);

    // R9 enable, R3 and R2 sweep: playback, 2 channels, 128 frames
    p_write(2'd1, 24'h100000);
    p_peek(2'd1, v); check("R9 ctrl readback", v, 32'h0010_0000);
    check("R9 play irq at empty", {31'd0, p_irq}, 1);
    for (int n = 1; n <= 256; n++) begin
      p_write(2'd0, pat(n));
      p_peek(2'd2, v);
      check("R3 play frames", v, 32'((n / 2) << 8));
      check("R9 play irq level", {31'd0, p_irq}, 32'((n / 2) <= 64));
    end
    // R2/R5: 257th word overruns and is dropped
    p_write(2'd0, 24'hDEAD01);
    p_peek(2'd2, v); check("R5 overrun flag, R2 capacity", v, 32'h0000_8010);

    // R7: keeping bit4 written as 1 keeps it, writing 0 clears
    p_write(2'd2, 24'h000010);
    p_peek(2'd2, v); check("R7 flag kept", v, 32'h0000_8010);
    p_write(2'd2, 24'h000000);
    p_peek(2'd2, v); check("R7 flags cleared", v, 32'h0000_8000);

    // R10: other direction's strobes ignored in playback
    @(negedge clk); p_rd = 1; p_addr = 0; #1 check("R10 play data read zero", p_rdata, 0);
    p_spush = 1; p_sdata = 24'h123456;
    @(negedge clk); p_rd = 0; p_spush = 0;
    p_peek(2'd2, v); check("R10 play fill unchanged", v, 32'h0000_8000);

    // R4: serial pops in order
    for (int n = 1; n <= 256; n++) begin
      @(negedge clk); p_spop = 1; #1 check("R4 play order", {8'd0, p_srdata}, {8'd0, pat(n)});
    end
    @(negedge clk); p_spop = 0;
    p_peek(2'd2, v); check("R4 play drained", v, 0);
    // R6 underrun
    @(negedge clk); p_spop = 1; #1 check("R6 zero data", {8'd0, p_srdata}, 0);
    @(negedge clk); p_spop = 0;
    p_peek(2'd2, v); check("R6 underrun flag", v, 32'h0000_0001);

    // R8 clear keeps flags
    for (int n = 0; n < 10; n++) p_write(2'd0, pat(n));
    p_peek(2'd2, v); check("R8 prefill", v, 32'h0000_0501);
    p_write(2'd1, 24'h100001);
    p_peek(2'd2, v); check("R8 cleared keeps flag", v, 32'h0000_0001);
    p_peek(2'd1, v); check("R8 self clear", v, 32'h0010_0000);
    p_write(2'd0, pat(99));
    @(negedge clk); p_spop = 1; #1 check("R8 fresh after clear", {8'd0, p_srdata}, {8'd0, pat(99)});
    @(negedge clk); p_spop = 0;

    // Capture, 3 channels: 64 frames, 192 words
    c_write(2'd1, 24'h100000);
    check("R9 cap irq empty", {31'd0, c_irq}, 0);
    for (int n = 1; n <= 192; n++) begin
      @(negedge clk); c_spush = 1; c_sdata = pat(n + 500);
      @(negedge clk); c_spush = 0;
      c_peek(2'd2, v);
      check("R3 cap frames", v, 32'((n / 3) << 8));
      check("R9 cap irq level", {31'd0, c_irq}, 32'((n / 3) >= 32));
    end
    @(negedge clk); c_spush = 1; c_sdata = 24'hBAD000;
    @(negedge clk); c_spush = 0;
    c_peek(2'd2, v); check("R5 cap overrun, R2 capacity", v, 32'h0000_4010);
    @(negedge clk); c_spop = 1;
    @(negedge clk); c_spop = 0;
    c_peek(2'd2, v); check("R10 cap ser_pop ignored", v, 32'h0000_4010);
    for (int n = 1; n <= 192; n++) begin
      @(negedge clk); c_rd = 1; c_addr = 0; #1 check("R4 cap order", c_rdata, {8'd0, pat(n + 500)});
    end
    @(negedge clk); c_rd = 0;
    @(negedge clk); c_rd = 1; c_addr = 0; #1 check("R6 cap zero data", c_rdata, 0);
    @(negedge clk); c_rd = 0;
    c_peek(2'd2, v); check("R6 cap underrun", v, 32'h0000_0011);
    c_write(2'd2, 24'h0);
    c_peek(2'd2, v); check("R7 cap clear both", v, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule